// File: doc/BRIEF.md
# Vertical Serration Reset Generator

This block watches an active-low composite sync input, clocked by a line-locked clock, for the long low pulses that make up the vertical serration interval. When the first such broad pulse of a field is recognised, it emits one registered vertical reset pulse. After that it ignores further broad pulses until a set number of lines has passed. The first reset after a field boundary therefore marks the field start. The serration pulses that follow in the same interval, and any noise inside the active picture, cannot trigger a second reset.

A standard-select input picks between two sets of timing constants. Each set has a line length in clocks, a broad-pulse threshold, a holdoff length in lines and a reset pulse width. A line counter output restarts at zero on every accepted reset and advances once per line, so neighbouring blocks can gate on line numbers within the field. The input is assumed to be already separated and digital. The clock comes from an external line-locked oscillator.

Top module: `vreset_gen`

## Requirements
- R1: `ntsc_sel` = 1 selects the NTSC constant set (`*_NTSC` parameters); `ntsc_sel` = 0 selects the PAL set (`*_PAL` parameters). The selection takes effect one clock after the input changes.
- R2: A low run of `csync_n` is broad only if it is seen low on at least BROAD consecutive rising edges, where BROAD is the active mode's threshold. A run of BROAD-1 edges or fewer, such as a horizontal sync pulse, never causes a reset.
- R3: For an accepted broad pulse, `vreset` goes high BROAD+IN_STAGES+1 clock cycles after the first edge at which `csync_n` is sampled low. With the default IN_STAGES = 1 this is BROAD+2 cycles. The configured delay must be below half a line.
- R4: `vreset` stays high for exactly PULSE clock cycles of the active mode, then returns low.
- R5: `line_count` becomes 0 on the edge where `vreset` rises and stays 0 for the whole pulse. It then increases by one every LINE clocks of the active mode. It is $clog2(max hold + 1) + 1 bits wide and saturates at all ones.
- R6: After a reset, broad pulses are ignored until `line_count` has reached HOLD of the active mode. A broad pulse whose reset would fall on the edge where that count is reached is ignored. The next one, one cycle later, is accepted.
- R7: Within one serration train of several broad pulses, only the first produces a reset.
- R8: While `rst` is high at a clock edge, `vreset` and `line_count` are cleared to 0, the holdoff is released and the width detector is cleared. The first broad pulse after reset is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked clock |
| rst | input | 1 | Synchronous active-high reset |
| csync_n | input | 1 | Composite sync, low during sync pulses |
| ntsc_sel | input | 1 | Standard select, 1 = NTSC, 0 = PAL |
| vreset | output | 1 | Registered vertical reset pulse |
| line_count | output | LCW | Lines since the last reset, saturating |

## Verification
The assertions assume that `ntsc_sel` changes only while the holdoff is released and no pulse is in flight. They also assume that the configured reset delay and pulse width both fit inside one line, so that a pulse never spans a line-count step. The stimulus keeps the select stable for a whole run of tests and lets the count pass the holdoff before switching. Random horizontal pulses are limited to lengths below the threshold, with gaps of several clocks. Broad pulses are timed relative to the observed reset, so that the holdoff edge is hit exactly from both sides.

// File: rtl/vrg_pkg.sv
package vrg_pkg;

  typedef enum logic {
    STD_PAL  = 1'b0,
    STD_NTSC = 1'b1
  } vrg_std_e;

  function automatic int unsigned vrg_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/vrg_width_classifier.sv
module vrg_width_classifier #(
  parameter int unsigned IN_STAGES = 1,
  parameter int unsigned CW        = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_n_i,
  input  logic [CW-1:0] thr_i,
  output logic          broad_o
);

  logic          samp;
  logic [CW-1:0] low_cnt;

  // input retiming chain, depth chosen by parameter
  generate
    if (IN_STAGES <= 1) begin : g_one
      logic stg_q;
      always_ff @(posedge clk) begin
        if (rst) stg_q <= 1'b1;
        else     stg_q <= sync_n_i;
      end
      assign samp = stg_q;
    end else begin : g_many
      logic [IN_STAGES-1:0] stg_q;
      always_ff @(posedge clk) begin
        if (rst) stg_q <= '1;
        else     stg_q <= {stg_q[IN_STAGES-2:0], sync_n_i};
      end
      assign samp = stg_q[IN_STAGES-1];
    end
  endgenerate

  // low-run length, saturating at the threshold; one hit per run
  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      broad_o <= 1'b0;
    end else begin
      broad_o <= (!samp) && (low_cnt == (thr_i - CW'(1)));
      if (samp)                low_cnt <= '0;
      else if (low_cnt < thr_i) low_cnt <= low_cnt + CW'(1);
    end
  end

endmodule

// File: rtl/vrg_line_timer.sv
module vrg_line_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart_i,
  input  logic [CW-1:0] len_i,
  output logic          tick_o
);

  logic [CW-1:0] pos_q;
  logic          at_end;

  assign at_end = (pos_q >= (len_i - CW'(1)));
  assign tick_o = at_end && !restart_i;

  always_ff @(posedge clk) begin
    if (rst)            pos_q <= '0;
    else if (restart_i) pos_q <= '0;
    else if (at_end)    pos_q <= '0;
    else                pos_q <= pos_q + CW'(1);
  end

endmodule

// File: rtl/vrg_holdoff.sv
module vrg_holdoff #(
  parameter int unsigned LCW = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           broad_i,
  input  logic           tick_i,
  input  logic [LCW-1:0] hold_i,
  output logic           fire_o,
  output logic [LCW-1:0] line_cnt_o
);

  logic         armed_q;
  logic [LCW:0] cnt_inc;

  assign fire_o  = broad_i && armed_q;
  assign cnt_inc = {1'b0, line_cnt_o} + {{LCW{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q    <= 1'b1;
      line_cnt_o <= '0;
    end else if (fire_o) begin
      armed_q    <= 1'b0;
      line_cnt_o <= '0;
    end else if (tick_i) begin
      if (line_cnt_o != '1) line_cnt_o <= cnt_inc[LCW-1:0];
      if (cnt_inc >= {1'b0, hold_i}) armed_q <= 1'b1;
    end
  end

endmodule

// File: rtl/vrg_pulse.sv
module vrg_pulse #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire_i,
  input  logic [CW-1:0] width_i,
  output logic          pulse_o
);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_o <= 1'b0;
      left_q  <= '0;
    end else if (fire_i) begin
      pulse_o <= 1'b1;
      left_q  <= width_i - CW'(1);
    end else if (pulse_o) begin
      if (left_q == '0) pulse_o <= 1'b0;
      else              left_q  <= left_q - CW'(1);
    end
  end

endmodule

// File: rtl/vreset_gen.sv
module vreset_gen
  import vrg_pkg::*;
#(
  parameter int unsigned LINE_CLKS_NTSC  = 910,
  parameter int unsigned LINE_CLKS_PAL   = 282,
  parameter int unsigned BROAD_CLKS_NTSC = 143,
  parameter int unsigned BROAD_CLKS_PAL  = 44,
  parameter int unsigned HOLD_LINES_NTSC = 256,
  parameter int unsigned HOLD_LINES_PAL  = 304,
  parameter int unsigned PULSE_CLKS_NTSC = 200,
  parameter int unsigned PULSE_CLKS_PAL  = 49,
  parameter int unsigned IN_STAGES       = 1,
  localparam int unsigned HOLD_MAX  = vrg_max(HOLD_LINES_NTSC, HOLD_LINES_PAL),
  localparam int unsigned LCW       = $clog2(HOLD_MAX + 1) + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           csync_n,
  input  logic           ntsc_sel,
  output logic           vreset,
  output logic [LCW-1:0] line_count
);

  localparam int unsigned CLK_MAX   = vrg_max(vrg_max(LINE_CLKS_NTSC, LINE_CLKS_PAL),
                                              vrg_max(PULSE_CLKS_NTSC, PULSE_CLKS_PAL));
  localparam int unsigned CW        = $clog2(CLK_MAX + 1);
  localparam int unsigned HOLD_MIN  = (HOLD_LINES_NTSC < HOLD_LINES_PAL) ? HOLD_LINES_NTSC : HOLD_LINES_PAL;
  localparam int unsigned PULSE_MAX = vrg_max(PULSE_CLKS_NTSC, PULSE_CLKS_PAL);

  vrg_std_e       mode_q;
  logic [CW-1:0]  line_len;
  logic [CW-1:0]  broad_thr;
  logic [CW-1:0]  pulse_len;
  logic [LCW-1:0] hold_len;
  logic           broad;
  logic           tick;
  logic           fire;

  always_ff @(posedge clk) begin
    mode_q <= vrg_std_e'(ntsc_sel);
  end

  always_comb begin
    if (mode_q == STD_NTSC) begin
      line_len  = CW'(LINE_CLKS_NTSC);
      broad_thr = CW'(BROAD_CLKS_NTSC);
      pulse_len = CW'(PULSE_CLKS_NTSC);
      hold_len  = LCW'(HOLD_LINES_NTSC);
    end else begin
      line_len  = CW'(LINE_CLKS_PAL);
      broad_thr = CW'(BROAD_CLKS_PAL);
      pulse_len = CW'(PULSE_CLKS_PAL);
      hold_len  = LCW'(HOLD_LINES_PAL);
    end
  end

  vrg_width_classifier #(.IN_STAGES(IN_STAGES), .CW(CW)) i_classifier (
    .clk      (clk),
    .rst      (rst),
    .sync_n_i (csync_n),
    .thr_i    (broad_thr),
    .broad_o  (broad)
  );

  vrg_line_timer #(.CW(CW)) i_line_timer (
    .clk       (clk),
    .rst       (rst),
    .restart_i (fire),
    .len_i     (line_len),
    .tick_o    (tick)
  );

  vrg_holdoff #(.LCW(LCW)) i_holdoff (
    .clk        (clk),
    .rst        (rst),
    .broad_i    (broad),
    .tick_i     (tick),
    .hold_i     (hold_len),
    .fire_o     (fire),
    .line_cnt_o (line_count)
  );

  vrg_pulse #(.CW(CW)) i_pulse (
    .clk     (clk),
    .rst     (rst),
    .fire_i  (fire),
    .width_i (pulse_len),
    .pulse_o (vreset)
  );

endmodule

// File: rtl/vrg_checker.sv
module vrg_checker #(
  parameter int unsigned LCW       = 10,
  parameter int unsigned HOLD_MIN  = 256,
  parameter int unsigned PULSE_MAX = 200,
  parameter int unsigned LINE_N    = 910,
  parameter int unsigned LINE_P    = 282,
  parameter int unsigned BROAD_N   = 143,
  parameter int unsigned BROAD_P   = 44,
  parameter int unsigned PULSE_N   = 200,
  parameter int unsigned PULSE_P   = 49,
  parameter int unsigned IN_STAGES = 1
) (
  input logic           clk,
  input logic           rst,
  input logic           vreset,
  input logic [LCW-1:0] line_count
);

  localparam int unsigned HW = $clog2(PULSE_MAX + 2) + 1;

  logic          seen_q;
  logic [HW-1:0] hi_cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q   <= 1'b0;
      hi_cnt_q <= '0;
    end else begin
      if (vreset) seen_q <= 1'b1;
      if (!vreset)             hi_cnt_q <= '0;
      else if (hi_cnt_q != '1) hi_cnt_q <= hi_cnt_q + HW'(1);
    end
  end

  initial begin
    AST_DELAY_HALF_LINE: assert ((BROAD_N + IN_STAGES + 1 < LINE_N / 2) && (BROAD_P + IN_STAGES + 1 < LINE_P / 2) && (BROAD_N > 0) && (BROAD_P > 0)) else $error("reset delay exceeds half a line"); // R3
    AST_PULSE_FITS_LINE: assert ((PULSE_N < LINE_N) && (PULSE_P < LINE_P) && (PULSE_N > 0) && (PULSE_P > 0)) else $error("pulse does not fit one line"); // R4
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!vreset && line_count == '0)); // R8
  AST_RISE_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst) $rose(vreset) |-> (line_count == '0)); // R5
  AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (rst) (line_count != $past(line_count)) |-> ((line_count == $past(line_count) + LCW'(1)) || (line_count == '0))); // R5
  AST_PULSE_IN_LINE0: assert property (@(posedge clk) disable iff (rst) vreset |-> (line_count == '0)); // R5
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (rst) ($rose(vreset) && seen_q) |-> ($past(line_count) >= LCW'(HOLD_MIN))); // R6
  AST_PULSE_BOUNDED: assert property (@(posedge clk) disable iff (rst) hi_cnt_q <= HW'(PULSE_MAX)); // R4

endmodule

bind vreset_gen vrg_checker #(
  .LCW       (LCW),
  .HOLD_MIN  (HOLD_MIN),
  .PULSE_MAX (PULSE_MAX),
  .LINE_N    (LINE_CLKS_NTSC),
  .LINE_P    (LINE_CLKS_PAL),
  .BROAD_N   (BROAD_CLKS_NTSC),
  .BROAD_P   (BROAD_CLKS_PAL),
  .PULSE_N   (PULSE_CLKS_NTSC),
  .PULSE_P   (PULSE_CLKS_PAL),
  .IN_STAGES (IN_STAGES)
) i_vrg_checker (
  .clk        (clk),
  .rst        (rst),
  .vreset     (vreset),
  .line_count (line_count)
);

// File: tb/test_vreset_gen.sv
module test_vreset_gen;

  localparam int N_LINE = 40, P_LINE = 30;
  localparam int N_THR  = 9,  P_THR  = 6;
  localparam int N_HOLD = 5,  P_HOLD = 7;
  localparam int N_PW   = 6,  P_PW   = 4;
  localparam int STG    = 1;
  localparam int LCW    = $clog2(((N_HOLD > P_HOLD) ? N_HOLD : P_HOLD) + 1) + 1;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           csync_n = 1'b1;
  logic           ntsc_sel = 1'b1;
  logic           vreset;
  logic [LCW-1:0] line_count;

  int now = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vreset_gen #(
    .LINE_CLKS_NTSC (N_LINE), .LINE_CLKS_PAL (P_LINE),
    .BROAD_CLKS_NTSC(N_THR),  .BROAD_CLKS_PAL(P_THR),
    .HOLD_LINES_NTSC(N_HOLD), .HOLD_LINES_PAL(P_HOLD),
    .PULSE_CLKS_NTSC(N_PW),   .PULSE_CLKS_PAL(P_PW),
    .IN_STAGES      (STG)
  ) i_vreset_gen (
    .clk        (clk),
    .rst        (rst),
    .csync_n    (csync_n),
    .ntsc_sel   (ntsc_sel),
    .vreset     (vreset),
    .line_count (line_count)
  );

  function automatic int m_line(bit n); return n ? N_LINE : P_LINE; endfunction
  function automatic int m_thr(bit n);  return n ? N_THR  : P_THR;  endfunction
  function automatic int m_hold(bit n); return n ? N_HOLD : P_HOLD; endfunction
  function automatic int m_pw(bit n);   return n ? N_PW   : P_PW;   endfunction
  function automatic int m_lat(bit n);  return m_thr(n) + STG + 1;  endfunction

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      now++;
    end
  endtask

  task automatic goto(int t);
    while (now < t) step(1);
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive low for len cycles inside a window of win cycles; report first rise and high count
  task automatic watch(int len, int win, output int rise, output int hi);
    bit prev;
    rise = -1;
    hi   = 0;
    prev = vreset;
    if (len > 0) csync_n = 1'b0;
    for (int i = 0; i < win; i++) begin
      if (i == len) csync_n = 1'b1;
      step(1);
      if (vreset) hi++;
      if (vreset && !prev && rise < 0) rise = i + 1;
      prev = vreset;
    end
    csync_n = 1'b1;
  endtask

  task automatic suite(bit n, output int f);
    int r, h, s, m, len, gap, L, T, H, W, LAT;
    L = m_line(n); T = m_thr(n); H = m_hold(n); W = m_pw(n); LAT = m_lat(n);
    ntsc_sel = n;
    step(3);
    for (int j = 0; j < 8; j++) begin
      len = int'($urandom_range(T - 1, 1));
      gap = int'($urandom_range(12, 3));
      watch(len, len + gap, r, h);
      chk(r < 0, "R2 short pulse ignored", r, -1);
    end
    watch(T - 1, T + 8, r, h);
    chk(r < 0, "R2 threshold minus one ignored", r, -1);
    s = now;
    watch(T, LAT + W + 3, r, h);
    chk(r == LAT, n ? "R3 delay NTSC" : "R1 R3 delay PAL", r, LAT);
    chk(h == W, n ? "R4 width NTSC" : "R1 R4 width PAL", h, W);
    f = s + r;
    chk(line_count == 0, "R5 count zero after reset pulse", int'(line_count), 0);
    for (int j = 0; j < 3; j++) begin
      watch(T + 4, T + 8, r, h);
      chk(r < 0, "R7 train pulse ignored", r, -1);
    end
    for (int k = 1; k < H; k++) begin
      if (f + k * L - 1 >= now) begin
        goto(f + k * L - 1);
        chk(int'(line_count) == k - 1, "R5 count before step", int'(line_count), k - 1);
        step(1);
        chk(int'(line_count) == k, n ? "R5 count step" : "R1 R5 count step", int'(line_count), k);
      end
    end
    m = f + H * L - T - 2;
    goto(m);
    watch(T, T + 8, r, h);
    chk(r < 0, "R6 reject on holdoff edge", r, -1);
    chk(int'(line_count) == H, "R5 count at holdoff", int'(line_count), H);
    s = now;
    watch(T + 3, LAT + W + 3, r, h);
    chk(r == LAT, "R6 accept after holdoff", r, LAT);
    f = s + r;
    goto(f + H * L - T - 1);
    s = now;
    watch(T, LAT + W + 3, r, h);
    chk(r == LAT, "R6 accept one cycle past holdoff", r, LAT);
    f = s + r;
  endtask

  initial begin
    int f, r, h, s, sat;
    void'($urandom(32'd1234));
    rst = 1'b1;
    step(3);
    chk(vreset == 1'b0, "R8 reset vreset", int'(vreset), 0);
    chk(line_count == 0, "R8 reset count", int'(line_count), 0);
    rst = 1'b0;
    step(1);

    suite(1'b1, f);

    sat = (1 << LCW) - 1;
    goto(f + (sat + 5) * N_LINE);
    chk(int'(line_count) == sat, "R5 saturation", int'(line_count), sat);

    s = now;
    watch(N_THR, m_lat(1'b1) + 2, r, h);
    chk(r == m_lat(1'b1), "R3 fire before reset test", r, m_lat(1'b1));
    step(5);
    rst = 1'b1;
    step(2);
    chk(vreset == 1'b0, "R8 mid holdoff vreset", int'(vreset), 0);
    chk(line_count == 0, "R8 mid holdoff count", int'(line_count), 0);
    rst = 1'b0;
    step(1);
    watch(N_THR, m_lat(1'b1) + N_PW + 3, r, h);
    chk(r == m_lat(1'b1), "R8 first pulse after reset accepted", r, m_lat(1'b1));
    goto(now + (P_HOLD + 2) * N_LINE);

    suite(1'b0, f);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", now, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule